// File: doc/BRIEF.md
# Conditional Select-Negate Execute Unit

This unit takes one 32-bit instruction word per cycle and runs a conditional select-negate against an internal bank of general-purpose registers, with the condition flags supplied on a 4-bit input. Decode checks the fixed opcode bits and pulls out the destination, first-source, second-source and condition fields. When the condition is true, the destination receives the first source. When it is false, the destination receives the two's-complement negative of the second source. A size bit in the word selects 32-bit or 64-bit operation for each instruction.

The unit also reports whether the word has the shape that is better written as a plain conditional negate: both source fields are equal and the condition is not one of the two always-true codes. Result, condition outcome, illegal flag and alias flag are combinational. The register write lands on the next rising clock edge. The datapath is one fixed-latency path, so timing never depends on the operand values.

The register bank has a load port and a peek port. These let the surrounding logic, or a test environment, set operands and observe destinations.

Top module: `csn_exec_unit`

## Requirements
- R1: A word is legal only when bits [30:21] equal 10'b1011010100 and bits [11:10] equal 2'b01. Any other word raises `illegal` and writes no register.
- R2: The condition field is bits [15:12] and the flags are `nzcv[3]`=N, `[2]`=Z, `[1]`=C, `[0]`=V. The even codes test the following: 0 tests Z set, 2 tests C set, 4 tests N set, 6 tests V set, 8 tests C set with Z clear, 10 tests N equal to V, and 12 tests Z clear with N equal to V. Each odd code below 14 is the inverse of the even code before it. Codes 14 and 15 are always true. The outcome is shown on `cond_pass`.
- R3: When the condition is true, `exec_result` is the register named by bits [9:5], at the operating width.
- R4: When the condition is false, `exec_result` is the bitwise inverse of the register named by bits [20:16] plus one, at the operating width. The most negative value at that width yields itself.
- R5: Bit 31 clear selects 32-bit operation. Only the low 32 bits of each source are used, and bits [63:32] of the result are zero. Bit 31 set selects 64-bit operation.
- R6: Register index 31 always reads as zero, and any write to it is dropped.
- R7: `alias_pref` is high exactly when the word is legal, the condition code is below 14, and bits [9:5] equal bits [20:16].
- R8: When `issue_valid` is high and the word is legal, `exec_result` is written to the register named by bits [4:0] at the next rising edge. If a load to the same index occurs in the same cycle, the executed result wins.
- R9: Reset clears every register to zero. `load_en` writes `load_data` to `load_idx` at the next rising edge, and `peek_data` shows the register named by `peek_idx` combinationally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | Execute the presented word this cycle |
| instr | input | 32 | Instruction word |
| nzcv | input | 4 | Condition flags N,Z,C,V (MSB first) |
| load_en | input | 1 | Register load strobe |
| load_idx | input | 5 | Register load index |
| load_data | input | 64 | Register load value |
| peek_idx | input | 5 | Register observe index |
| peek_data | output | 64 | Value of the observed register |
| exec_result | output | 64 | Value the instruction would write |
| cond_pass | output | 1 | Condition evaluated true |
| illegal | output | 1 | Fixed opcode bits do not match |
| alias_pref | output | 1 | Conditional-negate form preferred |

## Verification
An executed write-back and a register load can hit the same register index on the same clock edge. The bench provokes this by presenting a load and a legal issued word that both name one destination in a single cycle. It then peeks that register and expects the executed value, not the loaded one. Condition evaluation and the width choice are swept over every code, every flag pattern and both widths. Each result is compared against values computed arithmetically in the bench.

// File: rtl/csn_pkg.sv
package csn_pkg;
    localparam int IDX_W = 5;

    typedef struct packed {
        logic             wide;
        logic [IDX_W-1:0] src_m;
        logic [3:0]       code;
        logic [IDX_W-1:0] src_n;
        logic [IDX_W-1:0] dst;
        logic             legal;
    } csn_fields_t;

    localparam logic [9:0] OPC_HI = 10'b10_1101_0100;
    localparam logic [1:0] OPC_LO = 2'b01;
endpackage

// File: rtl/csn_decode.sv
module csn_decode
    import csn_pkg::*;
(
    input  logic [31:0] instr,
    output csn_fields_t fields
);
    always_comb begin
        fields.wide  = instr[31];
        fields.src_m = instr[20:16];
        fields.code  = instr[15:12];
        fields.src_n = instr[9:5];
        fields.dst   = instr[4:0];
        fields.legal = (instr[30:21] == OPC_HI) && (instr[11:10] == OPC_LO);
    end
endmodule

// File: rtl/csn_cond_eval.sv
module csn_cond_eval (
    input  logic [3:0] code,
    input  logic [3:0] nzcv,
    output logic       pass
);
    logic f_n, f_z, f_c, f_v, base;

    always_comb begin
        {f_n, f_z, f_c, f_v} = nzcv;
        unique case (code[3:1])
            3'd0:    base = f_z;
            3'd1:    base = f_c;
            3'd2:    base = f_n;
            3'd3:    base = f_v;
            3'd4:    base = f_c & ~f_z;
            3'd5:    base = (f_n == f_v);
            3'd6:    base = ~f_z & (f_n == f_v);
            default: base = 1'b1;
        endcase
        if (code[0] && (code[3:1] != 3'd7))
            pass = ~base;
        else
            pass = base;
    end
endmodule

// File: rtl/csn_regfile.sv
module csn_regfile #(
    parameter int XLEN  = 64,
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wb_en,
    input  logic [IDX_W-1:0] wb_idx,
    input  logic [XLEN-1:0]  wb_data,
    input  logic             ld_en,
    input  logic [IDX_W-1:0] ld_idx,
    input  logic [XLEN-1:0]  ld_data,
    input  logic [IDX_W-1:0] ra_idx,
    output logic [XLEN-1:0]  ra_data,
    input  logic [IDX_W-1:0] rb_idx,
    output logic [XLEN-1:0]  rb_data,
    input  logic [IDX_W-1:0] rp_idx,
    output logic [XLEN-1:0]  rp_data
);
    localparam int NREG = 1 << IDX_W;
    localparam logic [IDX_W-1:0] ZERO_IDX = IDX_W'(NREG - 1);

    logic [XLEN-1:0] mem [NREG];

    // The top entry is the hard zero register and never changes.
    assign mem[NREG-1] = '0;

    for (genvar g = 0; g < NREG - 1; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem[g] <= '0;
            else if (wb_en && (wb_idx == IDX_W'(g)))
                mem[g] <= wb_data;
            else if (ld_en && (ld_idx == IDX_W'(g)))
                mem[g] <= ld_data;
        end
    end

    always_comb begin
        ra_data = (ra_idx == ZERO_IDX) ? '0 : mem[ra_idx];
        rb_data = (rb_idx == ZERO_IDX) ? '0 : mem[rb_idx];
        rp_data = (rp_idx == ZERO_IDX) ? '0 : mem[rp_idx];
    end
endmodule

// File: rtl/csn_alu.sv
module csn_alu #(
    parameter int XLEN = 64
) (
    input  logic            wide,
    input  logic            pass,
    input  logic [XLEN-1:0] opnd_n,
    input  logic [XLEN-1:0] opnd_m,
    output logic [XLEN-1:0] result
);
    localparam int HALF = XLEN / 2;

    logic [XLEN-1:0] a_w, b_w, neg_b, pick;

    always_comb begin
        a_w = opnd_n;
        b_w = opnd_m;
        if (!wide) begin
            a_w[XLEN-1:HALF] = '0;
            b_w[XLEN-1:HALF] = '0;
        end
        neg_b = ~b_w + XLEN'(1);
        pick  = pass ? a_w : neg_b;
        if (!wide)
            pick[XLEN-1:HALF] = '0;
        result = pick;
    end
endmodule

// File: rtl/csn_exec_unit.sv
module csn_exec_unit
    import csn_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue_valid,
    input  logic [31:0]      instr,
    input  logic [3:0]       nzcv,
    input  logic             load_en,
    input  logic [IDX_W-1:0] load_idx,
    input  logic [XLEN-1:0]  load_data,
    input  logic [IDX_W-1:0] peek_idx,
    output logic [XLEN-1:0]  peek_data,
    output logic [XLEN-1:0]  exec_result,
    output logic             cond_pass,
    output logic             illegal,
    output logic             alias_pref
);
    csn_fields_t     fld;
    logic [XLEN-1:0] val_n, val_m;
    logic            wb_en;

    csn_decode u_dec (
        .instr  (instr),
        .fields (fld)
    );

    csn_cond_eval u_cond (
        .code (fld.code),
        .nzcv (nzcv),
        .pass (cond_pass)
    );

    csn_regfile #(.XLEN(XLEN), .IDX_W(IDX_W)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wb_en   (wb_en),
        .wb_idx  (fld.dst),
        .wb_data (exec_result),
        .ld_en   (load_en),
        .ld_idx  (load_idx),
        .ld_data (load_data),
        .ra_idx  (fld.src_n),
        .ra_data (val_n),
        .rb_idx  (fld.src_m),
        .rb_data (val_m),
        .rp_idx  (peek_idx),
        .rp_data (peek_data)
    );

    csn_alu #(.XLEN(XLEN)) u_alu (
        .wide   (fld.wide),
        .pass   (cond_pass),
        .opnd_n (val_n),
        .opnd_m (val_m),
        .result (exec_result)
    );

    always_comb begin
        illegal    = ~fld.legal;
        wb_en      = issue_valid & fld.legal;
        alias_pref = fld.legal && (fld.code[3:1] != 3'b111) && (fld.src_n == fld.src_m);
    end
endmodule

// File: rtl/csn_exec_chk.sv
module csn_exec_chk #(
    parameter int XLEN = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic            issue_valid,
    input logic [31:0]     instr,
    input logic            load_en,
    input logic [4:0]      peek_idx,
    input logic [XLEN-1:0] peek_data,
    input logic [XLEN-1:0] exec_result,
    input logic            cond_pass,
    input logic            illegal,
    input logic            alias_pref
);
    localparam int HALF = XLEN / 2;

    assert_zero_reg_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (peek_idx == 5'd31) |-> (peek_data == '0));

    assert_narrow_upper_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!illegal && !instr[31]) |-> (exec_result[XLEN-1:HALF] == '0));

    assert_always_true_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (instr[15:13] == 3'b111) |-> cond_pass);

    assert_alias_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
        alias_pref |-> !illegal);

    assert_zero_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_pass && instr[9:5] == 5'd31) |-> (exec_result == '0));

    assert_illegal_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && illegal && !load_en) |=>
            ($stable(peek_idx) -> $stable(peek_data)));
endmodule

bind csn_exec_unit csn_exec_chk #(.XLEN(XLEN)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .issue_valid (issue_valid),
    .instr       (instr),
    .load_en     (load_en),
    .peek_idx    (peek_idx),
    .peek_data   (peek_data),
    .exec_result (exec_result),
    .cond_pass   (cond_pass),
    .illegal     (illegal),
    .alias_pref  (alias_pref)
);

// File: tb/tb_csn_exec_unit.sv
module tb_csn_exec_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [3:0]  nzcv = '0;
    logic        load_en = 1'b0;
    logic [4:0]  load_idx = '0;
    logic [63:0] load_data = '0;
    logic [4:0]  peek_idx = '0;
    logic [63:0] peek_data, exec_result;
    logic        cond_pass, illegal, alias_pref;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    localparam logic [63:0] VAL_N = 64'h0123_4567_89AB_CDEF;
    localparam logic [63:0] VAL_M = 64'hFFFF_FFFF_0000_0005;

    always #2 clk = ~clk;

    csn_exec_unit dut (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .instr(instr),
        .nzcv(nzcv), .load_en(load_en), .load_idx(load_idx), .load_data(load_data),
        .peek_idx(peek_idx), .peek_data(peek_data), .exec_result(exec_result),
        .cond_pass(cond_pass), .illegal(illegal), .alias_pref(alias_pref)
    );

    function automatic logic [31:0] mk(input logic wide, input logic [4:0] rm,
                                       input logic [3:0] c, input logic [4:0] rn,
                                       input logic [4:0] rd);
        return {wide, 10'b1011010100, rm, c, 2'b01, rn, rd};
    endfunction

    function automatic logic want_cond(input logic [3:0] c, input logic [3:0] f);
        logic n, z, cy, v;
        {n, z, cy, v} = f;
        case (c)
            4'd0:  return z;
            4'd1:  return !z;
            4'd2:  return cy;
            4'd3:  return !cy;
            4'd4:  return n;
            4'd5:  return !n;
            4'd6:  return v;
            4'd7:  return !v;
            4'd8:  return cy && !z;
            4'd9:  return !(cy && !z);
            4'd10: return n == v;
            4'd11: return n != v;
            4'd12: return !z && (n == v);
            4'd13: return !(!z && (n == v));
            default: return 1'b1;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic load(input logic [4:0] idx, input logic [63:0] val);
        load_en = 1'b1; load_idx = idx; load_data = val;
        tick();
        load_en = 1'b0;
    endtask

    task automatic peek(input logic [4:0] idx, input logic [63:0] exp, input string req);
        peek_idx = idx;
        #1;
        check(peek_data === exp, req, peek_data, exp);
    endtask

    task automatic issue(input logic [31:0] w, input logic [3:0] f);
        instr = w; nzcv = f; issue_valid = 1'b1;
        tick();
        issue_valid = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        total++;
        bad++;
        $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
        finish_run();
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: all registers clear after reset
        for (int i = 0; i < 32; i++) peek(5'(i), 64'd0, "R9 reset");

        load(5'd1, VAL_N);
        load(5'd2, VAL_M);
        peek(5'd1, VAL_N, "R9 load");
        peek(5'd2, VAL_M, "R9 load");

        // R2 R3 R4 R5: full sweep of code, flags and width
        for (int w = 0; w < 2; w++) begin
            for (int c = 0; c < 16; c++) begin
                for (int f = 0; f < 16; f++) begin
                    logic [63:0] exp;
                    logic ct;
                    instr = mk(w[0], 5'd2, 4'(c), 5'd1, 5'd3);
                    nzcv = 4'(f);
                    #1;
                    ct = want_cond(4'(c), 4'(f));
                    check(cond_pass === ct, "R2 cond", {63'd0, cond_pass}, {63'd0, ct});
                    if (w == 1)
                        exp = ct ? VAL_N : (64'd0 - VAL_M);
                    else
                        exp = ct ? {32'd0, VAL_N[31:0]} : {32'd0, 32'd0 - VAL_M[31:0]};
                    check(exec_result === exp, ct ? "R3 select R5" : "R4 negate R5",
                          exec_result, exp);
                end
            end
        end

        // R8: write-back of true and false paths
        issue(mk(1'b1, 5'd2, 4'd14, 5'd1, 5'd3), 4'd0);
        peek(5'd3, VAL_N, "R8 writeback true");
        issue(mk(1'b1, 5'd2, 4'd0, 5'd1, 5'd4), 4'd0);
        peek(5'd4, 64'd0 - VAL_M, "R8 writeback negate");
        issue(mk(1'b0, 5'd2, 4'd14, 5'd1, 5'd4), 4'd0);
        peek(5'd4, {32'd0, VAL_N[31:0]}, "R5 narrow writeback");

        // R4: most negative value negates to itself
        load(5'd5, 64'h8000_0000_0000_0000);
        issue(mk(1'b1, 5'd5, 4'd0, 5'd1, 5'd6), 4'd0);
        peek(5'd6, 64'h8000_0000_0000_0000, "R4 min64");
        load(5'd5, 64'h1234_5678_8000_0000);
        issue(mk(1'b0, 5'd5, 4'd0, 5'd1, 5'd6), 4'd0);
        peek(5'd6, 64'h0000_0000_8000_0000, "R4 min32");

        // R6: zero register as source and destination
        instr = mk(1'b1, 5'd2, 4'd14, 5'd31, 5'd3); #1;
        check(exec_result === 64'd0, "R6 src n zero", exec_result, 64'd0);
        instr = mk(1'b1, 5'd31, 4'd0, 5'd1, 5'd3); nzcv = 4'd0; #1;
        check(exec_result === 64'd0, "R6 src m zero", exec_result, 64'd0);
        issue(mk(1'b1, 5'd2, 4'd14, 5'd1, 5'd31), 4'd0);
        peek(5'd31, 64'd0, "R6 write dropped");
        load(5'd31, 64'hDEAD);
        peek(5'd31, 64'd0, "R6 load dropped");

        // R1: broken opcode bits
        load(5'd7, 64'h77);
        begin
            logic [31:0] wbad;
            wbad = mk(1'b1, 5'd2, 4'd14, 5'd1, 5'd7) ^ 32'h2000_0000;
            instr = wbad; #1;
            check(illegal === 1'b1, "R1 illegal bit29", {63'd0, illegal}, 64'd1);
            issue(wbad, 4'd0);
            peek(5'd7, 64'h77, "R1 no write bit29");
            wbad = mk(1'b1, 5'd2, 4'd14, 5'd1, 5'd7) ^ 32'h0000_0400;
            instr = wbad; #1;
            check(illegal === 1'b1, "R1 illegal bit10", {63'd0, illegal}, 64'd1);
            check(alias_pref === 1'b0, "R7 illegal no alias", {63'd0, alias_pref}, 64'd0);
            issue(wbad, 4'd0);
            peek(5'd7, 64'h77, "R1 no write bit10");
            instr = mk(1'b0, 5'd2, 4'd14, 5'd1, 5'd7); #1;
            check(illegal === 1'b0, "R1 legal", {63'd0, illegal}, 64'd0);
        end

        // R7: alias sweep
        for (int c = 0; c < 16; c++) begin
            for (int n = 1; n < 3; n++) begin
                logic ea;
                instr = mk(1'b1, 5'd2, 4'(c), 5'(n), 5'd3);
                #1;
                ea = (c < 14) && (n == 2);
                check(alias_pref === ea, "R7 alias", {63'd0, alias_pref}, {63'd0, ea});
            end
        end

        // R8: load and execute to the same register in one cycle
        load_en = 1'b1; load_idx = 5'd8; load_data = 64'hAA;
        issue(mk(1'b1, 5'd2, 4'd14, 5'd1, 5'd8), 4'd0);
        load_en = 1'b0;
        peek(5'd8, VAL_N, "R8 collision");

        // R8: no write without issue_valid
        instr = mk(1'b1, 5'd2, 4'd14, 5'd1, 5'd9);
        tick();
        peek(5'd9, 64'd0, "R8 idle no write");

        finish_run();
    end
endmodule